// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits in front of a nonvolatile memory array and gathers byte writes into a page buffer of 128 slots. Each write pulse is built from three active-low strobes: chip enable, write enable and output enable. A pulse that passes qualification stores its byte in the slot chosen by the low address bits and marks that slot. The upper address bits of the first accepted byte fix the page for the whole operation. Bytes may arrive in any slot order, and a slot may be written again before the page is committed.

Loading stays open for as long as each accepted byte follows the previous one within a load window, counted in clock cycles. When the window runs out, the controller raises `busy` and enters a program period of fixed length. During that period it issues one array write per marked slot, in ascending slot order, on a simple commit port. When the period ends it clears every mark, drops `busy`, and accepts a new page operation.

All strobe inputs are assumed to be already synchronized to `clk`.

Top module: `pwb_top`

## Requirements
- R1: A write pulse is the span of cycles in which chip enable and write enable are both low and output enable is high. The address is sampled on the first clock edge of the pulse. The data byte is sampled on the edge at which chip enable or write enable has returned high. Address changes later in the pulse have no effect.
- R2: A pulse sampled active on fewer than FILTER_CYC clock edges is discarded. It stores nothing and does not open a page operation.
- R3: If output enable is low, no write happens. A pulse during which output enable goes low is discarded. Write enable low while chip enable is high writes nothing.
- R4: Address bits [6:0] select the slot and bits [16:7] select the page. Every commit write carries address {latched page, slot}, where the page comes from the first accepted byte of the operation.
- R5: Bytes may be loaded in any slot order, and the last byte loaded into a slot is the one committed. Only loaded slots are written. Writes come out in ascending slot order: the write for slot s is on the port, with `arrWrEn` high, during the single cycle after clock edge X+1+s, where X is the edge at which `busy` rose.
- R6: A byte whose end edge falls no more than WINDOW_CYC edges after the end edge of the previous accepted byte is added to the open page. `busy` rises at the WINDOW_CYC-th edge after the end edge of the last accepted byte.
- R7: While a page is open, a pulse whose page bits differ from the latched page is ignored. It does not restart the load window.
- R8: `busy` stays high for exactly PROG_CYC cycles. Pulses that end while `busy` is high are ignored and leave no trace afterwards.
- R9: When the program period ends, all marks are cleared. The next operation may use any page and commits only its own bytes.
- R10: After reset, `busy`, `arrWrEn`, `arrAddr` and `arrData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Chip enable, active low, synchronized |
| wrEnN | input | 1 | Write enable, active low, synchronized |
| outEnN | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | ADDR_W (17) | Byte address: page bits above the slot bits |
| dataIn | input | DATA_W (8) | Write data byte |
| busy | output | 1 | High during the program period |
| arrWrEn | output | 1 | One-cycle array write strobe |
| arrAddr | output | ADDR_W (17) | Array write address {page, slot} |
| arrData | output | DATA_W (8) | Array write data |

## Verification
Take a pulse whose last active edge is N. Its end edge is N+1, and the byte is stored at that edge. With no further loads, `busy` is seen high after edge N+1+WINDOW_CYC. The write for slot s then follows exactly s+1 cycles after `busy` rose, and `busy` falls PROG_CYC cycles after it rose. The bench drives every strobe on falling clock edges and counts rising edges, so it can compute each end edge exactly. A monitor samples on falling edges and records the cycle of every commit write and every `busy` transition. Each scenario then compares those recorded cycle numbers against expected values derived from the requirement timing above.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwbStateT;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capAddr;     // sample the bus address (pulse start)
    logic storeByte;   // write the byte into the page buffer and mark its slot
    logic takePage;    // first byte of an operation: latch the page
    logic emit;        // commit scan: present the slot on scanIdx
    logic clearMarks;  // end of program period
  } pwbStrobeT;

endpackage

// File: rtl/pwb_strobe_qual.sv
module pwb_strobe_qual #(
  parameter int FILTER_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipEnN,
  input  logic wrEnN,
  input  logic outEnN,
  output logic pulseStart,
  output logic pulseDone
);
  localparam int CNT_W = $clog2(FILTER_CYC + 1);

  logic             active;
  logic             activeQ;
  logic [CNT_W-1:0] widthCnt;

  assign active     = !chipEnN && !wrEnN && outEnN;
  assign pulseStart = active && !activeQ;
  // A pulse counts only when it is ended by chip or write enable (output
  // enable still high) and was wide enough to pass the noise filter.
  assign pulseDone  = activeQ && !active && outEnN &&
                      (widthCnt >= CNT_W'(FILTER_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      widthCnt <= '0;
    end else begin
      activeQ <= active;
      if (!active)
        widthCnt <= '0;
      else if (widthCnt != CNT_W'(FILTER_CYC))
        widthCnt <= widthCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl import pwb_pkg::*; #(
  parameter int SLOT_W     = 7,
  parameter int WINDOW_CYC = 15000,
  parameter int PROG_CYC   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseStart,
  input  logic              pulseDone,
  input  logic              pageHit,
  output pwbStrobeT         strb,
  output logic [SLOT_W-1:0] scanIdx,
  output logic              busy
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  pwbStateT          state;
  logic [WIN_W-1:0]  winCnt;
  logic [PROG_W-1:0] progCnt;
  logic              accept;

  always_comb begin
    accept = pulseDone &&
             ((state == ST_IDLE) || ((state == ST_LOAD) && pageHit));
    strb.capAddr    = pulseStart;
    strb.storeByte  = accept;
    strb.takePage   = accept && (state == ST_IDLE);
    strb.emit       = (state == ST_PROG) && (progCnt < PROG_W'(SLOTS));
    strb.clearMarks = (state == ST_PROG) && (progCnt == PROG_W'(PROG_CYC - 1));
  end

  assign scanIdx = progCnt[SLOT_W-1:0];
  assign busy    = (state == ST_PROG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_LOAD;
            winCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            winCnt <= '0;
          end else if (winCnt == WIN_W'(WINDOW_CYC - 1)) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (progCnt == PROG_W'(PROG_CYC - 1))
            state <= ST_IDLE;
          else
            progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath import pwb_pkg::*; #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobeT         strb,
  input  logic [SLOT_W-1:0] scanIdx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              pageHit,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [ADDR_W-1:0] addrLat;
  logic [PAGE_W-1:0] pageReg;
  logic [DATA_W-1:0] pageBuf [SLOTS];
  logic [SLOTS-1:0]  marks;
  logic [SLOT_W-1:0] loadSlot;
  logic [PAGE_W-1:0] loadPage;

  assign loadSlot = addrLat[SLOT_W-1:0];
  assign loadPage = addrLat[ADDR_W-1:SLOT_W];
  assign pageHit  = (loadPage == pageReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat <= '0;
      pageReg <= '0;
    end else begin
      if (strb.capAddr)  addrLat <= addr;
      if (strb.takePage) pageReg <= loadPage;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeByte) pageBuf[loadSlot] <= dataIn;
  end

  // One mark flop per slot
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        marks[gi] <= 1'b0;
      else if (strb.clearMarks || (strb.emit && (scanIdx == SLOT_W'(gi))))
        marks[gi] <= 1'b0;
      else if (strb.storeByte && (loadSlot == SLOT_W'(gi)))
        marks[gi] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrWrEn <= 1'b0;
      arrAddr <= '0;
      arrData <= '0;
    end else if (strb.emit) begin
      arrWrEn <= marks[scanIdx];
      arrAddr <= {pageReg, scanIdx};
      arrData <= pageBuf[scanIdx];
    end else begin
      arrWrEn <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top import pwb_pkg::*; #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 7,
  parameter int FILTER_CYC = 2,
  parameter int WINDOW_CYC = 15000,
  parameter int PROG_CYC   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              wrEnN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);
  pwbStrobeT         strb;
  logic [SLOT_W-1:0] scanIdx;
  logic              pulseStart;
  logic              pulseDone;
  logic              pageHit;

  pwb_strobe_qual #(.FILTER_CYC(FILTER_CYC)) i_qual (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .wrEnN(wrEnN),
    .outEnN(outEnN), .pulseStart(pulseStart), .pulseDone(pulseDone)
  );

  pwb_ctrl #(.SLOT_W(SLOT_W), .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .pulseStart(pulseStart), .pulseDone(pulseDone),
    .pageHit(pageHit), .strb(strb), .scanIdx(scanIdx), .busy(busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx), .addr(addr),
    .dataIn(dataIn), .pageHit(pageHit), .arrWrEn(arrWrEn),
    .arrAddr(arrAddr), .arrData(arrData)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W   = 17,
  parameter int SLOT_W   = 7,
  parameter int PROG_CYC = 1000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrAddr
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R5: commit writes only inside the program period
  p_emit_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  // R5: back-to-back writes have strictly rising slot numbers
  p_slot_ascending_r5: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |->
      (arrAddr[SLOT_W-1:0] > $past(arrAddr[SLOT_W-1:0])));

  // R4: page bits do not change inside one commit
  p_page_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |-> $stable(arrAddr[ADDR_W-1:SLOT_W]));

  // R8: program period length
  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == PROG_CYC));

  // R8: busy does not glitch after rising
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  // R9: no write after the period ends
  p_quiet_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !arrWrEn);
endmodule

bind pwb_top pwb_checker #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PROG_CYC(PROG_CYC)
) i_pwb_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .arrWrEn(arrWrEn), .arrAddr(arrAddr)
);

// File: tb/test_pwb_top.sv
module test_pwb_top;
  localparam int FILT = 2;
  localparam int WIN  = 20;
  localparam int PROG = 160;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        busy, arrWrEn;
  logic [16:0] arrAddr;
  logic [7:0]  arrData;

  int nChecks = 0, nFail = 0;
  int cyc = 0;
  int lastEnd = 0;
  bit finished = 1'b0;

  // Capture of commit activity
  logic [16:0] wAddr [256];
  logic [7:0]  wData [256];
  int          wCyc  [256];
  int          nW = 0;
  int          riseCyc = -1, fallCyc = -1;
  bit          riseSeen = 0, fallSeen = 0;
  logic        prevBusy = 1'b0;

  pwb_top #(.FILTER_CYC(FILT), .WINDOW_CYC(WIN), .PROG_CYC(PROG)) i_pwb_top (
    .clk(clk), .rstN(rstN), .chipEnN(ceN), .wrEnN(weN), .outEnN(oeN),
    .addr(addr), .dataIn(dataIn), .busy(busy), .arrWrEn(arrWrEn),
    .arrAddr(arrAddr), .arrData(arrData)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (arrWrEn && nW < 256) begin
      wAddr[nW] = arrAddr;
      wData[nW] = arrData;
      wCyc[nW]  = cyc;
      nW++;
    end
    if (busy && !prevBusy && !riseSeen) begin riseSeen = 1; riseCyc = cyc; end
    if (!busy && prevBusy && !fallSeen) begin fallSeen = 1; fallCyc = cyc; end
    prevBusy = busy;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCap();
    nW = 0; riseSeen = 0; fallSeen = 0; riseCyc = -1; fallCyc = -1;
  endtask

  // Write pulse of width w edges; chip enable or write enable controlled.
  // Entered and left on a falling edge. Sets lastEnd to the end edge.
  task automatic doLoad(input logic [16:0] a, input logic [7:0] d, input int w,
                        input bit ceCtl);
    oeN = 1'b1;
    if (ceCtl) begin
      weN = 1'b0; addr = ~a;
      @(negedge clk);
    end
    addr = a; dataIn = ~d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    addr = ~a;
    repeat (w - 1) @(negedge clk);
    dataIn = d;
    if (ceCtl) ceN = 1'b1; else weN = 1'b1;
    lastEnd = cyc + 1;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; addr = '0; dataIn = '0;
  endtask

  task automatic doLoadEndAt(input int endCyc, input logic [16:0] a, input logic [7:0] d);
    while (cyc < endCyc - FILT - 1) @(negedge clk);
    doLoad(a, d, FILT, 1'b0);
  endtask

  task automatic waitCommit();
    for (int g = 0; g < 3000 && !fallSeen; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chkWrite(input string req, input int idx, input logic [9:0] pg,
                          input int slot, input logic [7:0] d);
    chk(req, "commit address", int'(wAddr[idx]), int'({pg, 7'(slot)}));
    chk(req, "commit data", int'(wData[idx]), int'(d));
    chk(req, "commit cycle", wCyc[idx], riseCyc + 1 + slot);
  endtask

  function automatic logic [16:0] mk(input logic [9:0] pg, input int slot);
    return {pg, 7'(slot)};
  endfunction

  // R10
  task automatic testReset();
    chk("R10", "busy after reset", int'(busy), 0);
    chk("R10", "arrWrEn after reset", int'(arrWrEn), 0);
    chk("R10", "arrAddr after reset", int'(arrAddr), 0);
    chk("R10", "arrData after reset", int'(arrData), 0);
  endtask

  // R1 R4 R5 R6 R8: out-of-order loads, overwrite, both strobe styles
  task automatic testBasicPage();
    clearCap();
    doLoad(mk(10'h155, 5), 8'h11, 2, 1'b0);
    doLoad(mk(10'h155, 2), 8'h22, 3, 1'b1);
    doLoad(mk(10'h155, 127), 8'h44, 2, 1'b0);
    doLoad(mk(10'h155, 5), 8'h33, 4, 1'b0);
    waitCommit();
    chk("R6", "busy rise edge", riseCyc, lastEnd + WIN);
    chk("R8", "busy fall edge", fallCyc, riseCyc + PROG);
    chk("R5", "write count", nW, 3);
    chkWrite("R5", 0, 10'h155, 2, 8'h22);
    chkWrite("R1", 1, 10'h155, 5, 8'h33);
    chkWrite("R4", 2, 10'h155, 127, 8'h44);
  endtask

  // R2: narrow pulse discarded
  task automatic testNarrow();
    clearCap();
    doLoad(mk(10'h003, 9), 8'h99, 1, 1'b0);
    repeat (WIN + 5) @(negedge clk);
    chk("R2", "busy after narrow pulse", int'(riseSeen), 0);
    doLoad(mk(10'h003, 10), 8'hA0, FILT, 1'b0);
    waitCommit();
    chk("R2", "write count", nW, 1);
    chkWrite("R2", 0, 10'h003, 10, 8'hA0);
  endtask

  // R3: output enable and chip enable inhibit
  task automatic testInhibit();
    clearCap();
    addr = mk(10'h0F0, 50); dataIn = 8'h50;
    oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk);
    oeN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    oeN = 1'b1; ceN = 1'b1; weN = 1'b0;
    repeat (4) @(negedge clk);
    weN = 1'b1;
    repeat (WIN + 5) @(negedge clk);
    chk("R3", "busy after inhibited pulses", int'(riseSeen), 0);
    doLoad(mk(10'h0F1, 60), 8'h61, FILT, 1'b0);
    waitCommit();
    chk("R3", "busy rise after valid load", riseCyc, lastEnd + WIN);
    chk("R3", "write count", nW, 1);
    chkWrite("R3", 0, 10'h0F1, 60, 8'h61);
  endtask

  // R7: other page ignored and does not extend window
  task automatic testPageMismatch();
    int firstEnd;
    clearCap();
    doLoad(mk(10'h007, 1), 8'h71, FILT, 1'b0);
    firstEnd = lastEnd;
    repeat (8) @(negedge clk);
    doLoad(mk(10'h008, 2), 8'h82, FILT, 1'b0);
    waitCommit();
    chk("R7", "busy rise ignores foreign page", riseCyc, firstEnd + WIN);
    chk("R7", "write count", nW, 1);
    chkWrite("R7", 0, 10'h007, 1, 8'h71);
  endtask

  // R6 window boundary, R8 load during busy
  task automatic testWindowEdge();
    int e1;
    clearCap();
    doLoad(mk(10'h02A, 3), 8'hA3, FILT, 1'b0);
    e1 = lastEnd;
    doLoadEndAt(e1 + WIN, mk(10'h02A, 4), 8'hA4);
    waitCommit();
    chk("R6", "busy rise after boundary load", riseCyc, e1 + 2 * WIN);
    chk("R6", "write count", nW, 2);
    chkWrite("R6", 0, 10'h02A, 3, 8'hA3);
    chkWrite("R6", 1, 10'h02A, 4, 8'hA4);

    clearCap();
    doLoad(mk(10'h02B, 6), 8'hB6, FILT, 1'b0);
    e1 = lastEnd;
    doLoadEndAt(e1 + WIN + 1, mk(10'h02B, 7), 8'hB7);
    waitCommit();
    chk("R8", "busy rise", riseCyc, e1 + WIN);
    chk("R8", "write count with late load", nW, 1);
    chkWrite("R8", 0, 10'h02B, 6, 8'hB6);
    clearCap();
    repeat (WIN + 10) @(negedge clk);
    chk("R8", "no operation from load during busy", int'(riseSeen), 0);
  endtask

  // R9: marks cleared, old slots not replayed
  task automatic testFresh();
    clearCap();
    doLoad(mk(10'h155, 100), 8'hD4, FILT, 1'b0);
    waitCommit();
    chk("R9", "write count", nW, 1);
    chkWrite("R9", 0, 10'h155, 100, 8'hD4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicPage();
    testNarrow();
    testInhibit();
    testPageMismatch();
    testWindowEdge();
    testFresh();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule